// File: doc/BRIEF.md
# Serial Control Word Loader for a Frequency Synthesizer

This block assembles a 40-bit synthesizer control word that arrives one bit per rising edge of a slow serial write clock, least significant bit first. The bits collect in a shadow shift register. Nothing reaches the outputs until a separate update strobe rises. At that point the shadow word is checked, and if it is accepted it is copied into an active register. The active register drives the tuning word, the phase offset, the clock-multiplier enable and the power-down control.

The serial clock, serial data and update strobe are asynchronous to the system clock. All three pass through the same chain of synchronizer flops, so data and clock stay aligned, and their edges are detected in the system clock domain. Leaving power-down starts a wake-up timer, counted in system clock cycles. A ready flag stays low until that timer has run out. A malformed update leaves the active register as it was and raises a sticky error flag.

Top module: `dds_ctrl_loader`

## Requirements
- R1: The first serial bit shifted in lands in word bit 0. After 40 bits and an update, `ftw_o` equals word bits 31..0, with bit 0 as its LSB.
- R2: Shifted bits have no effect on any output until the update strobe rises. The active outputs change only after an update edge.
- R3: Word bit 32 drives `mult_en_o`. Word bits 39..35 drive `phase_o`, with bit 35 as its LSB.
- R4: An update whose word has bit 33 set is rejected. All active outputs keep their values and `load_err_o` goes high.
- R5: An update after any bit count other than exactly 40 (fewer or more) is rejected with the active outputs unchanged and `load_err_o` set. `load_err_o` then stays high until reset.
- R6: The bit counter restarts from zero after every update, whether that update was accepted or rejected.
- R7: An accepted word with bit 34 set drives `pdn_o` high. `ready_o` is low in every cycle in which `pdn_o` is high.
- R8: When an accepted word clears bit 34, `ready_o` rises exactly WAKE_CYCLES system clock cycles after `pdn_o` falls.
- R9: The shift register keeps accepting bits while powered down. A word shifted in during power-down is applied by the next update.
- R10: After reset all active outputs are zero, `ready_o` is 1 and `load_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Asynchronous serial write clock; a bit is taken on each rising edge |
| ser_data | input | 1 | Asynchronous serial data bit |
| upd_strobe | input | 1 | Asynchronous update strobe; its rising edge transfers the shadow word |
| ftw_o | output | 32 | Active frequency tuning word |
| phase_o | output | 5 | Active phase offset |
| mult_en_o | output | 1 | Active reference multiplier enable |
| pdn_o | output | 1 | Active power-down control |
| ready_o | output | 1 | High when powered up and the wake-up time has elapsed |
| load_err_o | output | 1 | Sticky flag for a rejected update |

## Verification
The hardest case to reach from the ports is the exact wake-up edge. It needs a full 40-bit power-down word to be accepted, then a second word that clears bit 34, and only then can the cycle in which `pdn_o` falls be located. The bench does this by raising the strobe and polling at every falling system clock edge until `pdn_o` changes. From that point it counts cycles until `ready_o` rises, which tests the timer against WAKE_CYCLES exactly. A second hard case is proving that the counter restarts after a rejected update. For that, the bench issues a deliberately short load and then an update, and shows that the following 40-bit load is accepted.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

    localparam int WORD_W = 40;
    localparam int FTW_W  = 32;
    localparam int PH_W   = 5;

    // Packed from MSB down: bit positions follow the serial bit order
    typedef struct packed {
        logic [PH_W-1:0]  phase;   // bits 39..35
        logic             pdn;     // bit 34
        logic             rsvd;    // bit 33, must be zero
        logic             mult;    // bit 32
        logic [FTW_W-1:0] ftw;     // bits 31..0
    } ctrl_word_t;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_ACCEPT = 2'd1,
        UPD_REJECT = 2'd2
    } upd_kind_t;

    function automatic upd_kind_t classify_update(input logic evt,
                                                  input logic full,
                                                  input ctrl_word_t w);
        if (!evt)
            return UPD_NONE;
        if (full && !w.rsvd)
            return UPD_ACCEPT;
        return UPD_REJECT;
    endfunction

endpackage

// File: rtl/ldr_sync.sv
module ldr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ldr_rise.sv
module ldr_rise #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/ldr_shifter.sv
module ldr_shifter
    import dds_ldr_pkg::*;
#(
    localparam int CNT_W = $clog2(WORD_W + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_evt,
    input  logic             bit_val,
    input  logic             clr,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

    logic [WORD_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;

    // New bits enter at the top so the first bit ends in position 0
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (bit_evt) begin
            sr_q  <= {bit_val, sr_q[WORD_W-1:1]};
            if (cnt_q != CNT_SAT)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign word_o = sr_q;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/ldr_wake_timer.sv
module ldr_wake_timer #(
    parameter int CYCLES = 500,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic pdn,
    output logic ready_o
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (pdn)           cnt_q <= LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign ready_o = !pdn && (cnt_q == '0);
endmodule

// File: rtl/dds_ctrl_loader.sv
module dds_ctrl_loader
    import dds_ldr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             upd_strobe,
    output logic [FTW_W-1:0] ftw_o,
    output logic [PH_W-1:0]  phase_o,
    output logic             mult_en_o,
    output logic             pdn_o,
    output logic             ready_o,
    output logic             load_err_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic [2:0]        lvl;
    logic [1:0]        rise;
    logic              bit_evt, upd_evt;
    logic [WORD_W-1:0] shadow;
    logic [CNT_W-1:0]  bit_cnt;
    ctrl_word_t        shadow_w, active_q;
    upd_kind_t         upd_kind;
    logic              err_q;
    logic              act_rsvd;

    // Data travels with the clock so both see identical latency
    ldr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_data, upd_strobe, ser_clk}),
        .sync_o  (lvl)
    );

    ldr_rise #(.W(2)) u_rise (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl[1:0]),
        .rise_o (rise)
    );

    assign bit_evt = rise[0];
    assign upd_evt = rise[1];

    ldr_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .bit_evt (bit_evt),
        .bit_val (lvl[2]),
        .clr     (upd_evt),
        .word_o  (shadow),
        .cnt_o   (bit_cnt)
    );

    assign shadow_w = ctrl_word_t'(shadow);
    assign upd_kind = classify_update(upd_evt, bit_cnt == CNT_FULL, shadow_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            err_q    <= 1'b0;
        end else begin
            case (upd_kind)
                UPD_ACCEPT: active_q <= shadow_w;
                UPD_REJECT: err_q    <= 1'b1;
                default: ;
            endcase
        end
    end

    ldr_wake_timer #(.CYCLES(WAKE_CYCLES)) u_wake (
        .clk     (clk),
        .rst     (rst),
        .pdn     (active_q.pdn),
        .ready_o (ready_o)
    );

    assign act_rsvd   = active_q.rsvd;
    assign ftw_o      = active_q.ftw;
    assign phase_o    = active_q.phase;
    assign mult_en_o  = active_q.mult;
    assign pdn_o      = active_q.pdn;
    assign load_err_o = err_q;
endmodule

// File: rtl/dds_ctrl_loader_chk.sv
module dds_ctrl_loader_chk (
    input logic        clk,
    input logic        rst,
    input logic        upd_evt,
    input logic        act_rsvd,
    input logic [31:0] ftw_o,
    input logic [4:0]  phase_o,
    input logic        mult_en_o,
    input logic        pdn_o,
    input logic        ready_o,
    input logic        load_err_o
);
    // R2: outputs move only in the cycle after an update event
    a_r2_hold_no_update: assert property (@(posedge clk) disable iff (rst)
        !upd_evt |=> ($stable(ftw_o) && $stable(phase_o)
                      && $stable(mult_en_o) && $stable(pdn_o)));

    // R4: the reserved bit never reaches the active register
    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        !act_rsvd);

    // R5: error flag is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
        load_err_o |=> load_err_o);

    // R7: never ready while powered down
    a_r7_no_ready_in_pdn: assert property (@(posedge clk) disable iff (rst)
        pdn_o |-> !ready_o);

    // R8: leaving power-down does not give ready at once
    a_r8_wake_delayed: assert property (@(posedge clk) disable iff (rst)
        $fell(pdn_o) |-> !ready_o);
endmodule

bind dds_ctrl_loader dds_ctrl_loader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .upd_evt    (upd_evt),
    .act_rsvd   (act_rsvd),
    .ftw_o      (ftw_o),
    .phase_o    (phase_o),
    .mult_en_o  (mult_en_o),
    .pdn_o      (pdn_o),
    .ready_o    (ready_o),
    .load_err_o (load_err_o)
);

// File: tb/tb_dds_ctrl_loader.sv
module tb_dds_ctrl_loader;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE       = 500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_data = 1'b0, upd_strobe = 1'b0;
    logic [31:0] ftw_o;
    logic [4:0]  phase_o;
    logic        mult_en_o, pdn_o, ready_o, load_err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_ctrl_loader #(.SYNC_STAGES(2), .WAKE_CYCLES(WAKE)) dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .upd_strobe(upd_strobe), .ftw_o(ftw_o), .phase_o(phase_o),
        .mult_en_o(mult_en_o), .pdn_o(pdn_o), .ready_o(ready_o),
        .load_err_o(load_err_o)
    );

    // Word layout: [39:35] phase, [34] power-down, [33] must be 0, [32] multiplier, [31:0] tuning
    function automatic logic [39:0] mk(input logic [31:0] f, input logic m,
                                       input logic r, input logic p,
                                       input logic [4:0] ph);
        return {ph, p, r, m, f};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ser_clk = 1'b0; ser_data = 1'b0; upd_strobe = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [39:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = (i < 40) ? w[i] : 1'b0;
            @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic update();
        upd_strobe = 1'b1;
        repeat (4) @(negedge clk);
        upd_strobe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 ftw", 64'(ftw_o), 0);
        chk("R10 phase", 64'(phase_o), 0);
        chk("R10 mult/pdn", {62'd0, mult_en_o, pdn_o}, 0);
        chk("R10 ready", 64'(ready_o), 1);
        chk("R10 err", 64'(load_err_o), 0);
    endtask

    task automatic t_basic();
        logic [39:0] w = mk(32'hA5C3_0F1E, 1'b1, 1'b0, 1'b0, 5'h13);
        shift_bits(w, 40);
        chk("R2 no effect before update", 64'(ftw_o), 0);
        update();
        chk("R1 ftw", 64'(ftw_o), 64'h A5C3_0F1E);
        chk("R3 phase", 64'(phase_o), 5'h13);
        chk("R3 mult", 64'(mult_en_o), 1);
        chk("R1 no err", 64'(load_err_o), 0);
        w = mk(32'h8000_0001, 1'b0, 1'b0, 1'b0, 5'h01);
        shift_bits(w, 40);
        chk("R2 old ftw held", 64'(ftw_o), 64'h A5C3_0F1E);
        update();
        chk("R1 lsb/msb ftw", 64'(ftw_o), 64'h8000_0001);
        chk("R3 phase lsb", 64'(phase_o), 1);
        chk("R3 mult off", 64'(mult_en_o), 0);
    endtask

    task automatic t_short();
        shift_bits(mk(32'h1111_2222, 1'b1, 1'b0, 1'b0, 5'h1F), 39);
        update();
        chk("R5 short rejected", 64'(ftw_o), 64'h8000_0001);
        chk("R5 short err", 64'(load_err_o), 1);
        shift_bits(mk(32'h3333_4444, 1'b0, 1'b0, 1'b0, 5'h02), 40);
        update();
        chk("R6 counter restarted", 64'(ftw_o), 64'h3333_4444);
        chk("R5 err sticky", 64'(load_err_o), 1);
    endtask

    task automatic t_long();
        do_reset();
        shift_bits(mk(32'h5555_AAAA, 1'b0, 1'b0, 1'b0, 5'h04), 41);
        update();
        chk("R5 long rejected", 64'(ftw_o), 0);
        chk("R5 long err", 64'(load_err_o), 1);
    endtask

    task automatic t_rsvd();
        do_reset();
        shift_bits(mk(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 5'h0A), 40);
        update();
        chk("R4 rsvd rejected ftw", 64'(ftw_o), 0);
        chk("R4 rsvd rejected mult", 64'(mult_en_o), 0);
        chk("R4 err", 64'(load_err_o), 1);
    endtask

    task automatic t_power();
        int n;
        do_reset();
        shift_bits(mk(32'h0000_0F00, 1'b0, 1'b0, 1'b1, 5'h00), 40);
        upd_strobe = 1'b1;
        n = 0;
        while (pdn_o !== 1'b1 && n < 20) begin @(negedge clk); n++; end
        chk("R7 pdn set", 64'(pdn_o), 1);
        chk("R7 ready low", 64'(ready_o), 0);
        repeat (4) @(negedge clk);
        upd_strobe = 1'b0;
        repeat (4) @(negedge clk);
        shift_bits(mk(32'h1234_5678, 1'b1, 1'b0, 1'b0, 5'h07), 40);
        chk("R7 still down", {63'd0, ready_o}, 0);
        upd_strobe = 1'b1;
        n = 0;
        while (pdn_o !== 1'b0 && n < 20) begin @(negedge clk); n++; end
        upd_strobe = 1'b0;
        chk("R9 word loaded while down", 64'(ftw_o), 64'h1234_5678);
        chk("R9 phase", 64'(phase_o), 7);
        n = 0;
        while (ready_o !== 1'b1 && n < WAKE + 50) begin @(negedge clk); n++; end
        chk("R8 wake cycles", 64'(n), 64'(WAKE));
    endtask

    initial begin
        do_reset();
        t_reset();
        t_basic();
        t_short();
        t_long();
        t_rsvd();
        t_power();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule